// File: doc/BRIEF.md
# Bit-Masked GPIO Data Port

An eight-pin general-purpose I/O port on a simple synchronous register bus. Four registers control it: the pin data value, the pin direction, a per-pin hand-over to a peripheral, and a per-pin digital enable. The data register is reached through a window of word addresses. The low word-address bits form a per-pin mask, so software can set, clear or sample any subset of pins with a single bus access and no read-modify-write.

Each pin's output value and output enable come either from the data and direction registers or, when the pin is handed to a peripheral, from the peripheral's own value and enable inputs. Pin inputs are brought into the clock domain through a two-flop synchronizer. The synchronized levels feed both the register read path and the peripheral, gated by the digital enable.

The bus uses word addresses. Word-address bit 8 clear selects the data window, and bits [7:0] are the pin mask; these are byte-address bits [9:2]. Word-address bit 8 set selects a control register through bits [1:0]: 0 is direction, 1 is peripheral select, 2 is digital enable, and 3 is unused.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the data, direction, peripheral-select and digital-enable registers are all zero. As a result pinOe and pinOut are 0, and every register reads 0.
- R2: A write in the data window (busAddr[8]=0) updates only the data bits whose mask bit busAddr[7:0] is 1. Every other data bit keeps its value.
- R3: A read in the data window returns 0 in every bit whose mask bit busAddr[7:0] is 0, whatever the pin or register value.
- R4: For a masked-in bit, a data read returns the stored data bit when the direction bit is 1 (output). When the direction bit is 0 (input), it returns the synchronized pin level.
- R5: A pinIn change is missed by reads whose strobe is sampled at the first and second rising edges after the change. It is first returned by a read sampled at the third edge.
- R6: Word addresses 0x100, 0x101 and 0x102 write and read back the direction, peripheral-select and digital-enable registers. Address 0x103 reads 0, and a write to it changes nothing.
- R7: When a pin's peripheral-select bit is 0, its pinOut equals its data bit, and its pinOe equals direction AND digital enable.
- R8: When a pin's peripheral-select bit is 1, its pinOut equals periphOut, and its pinOe equals periphOe AND digital enable.
- R9: When a pin's digital-enable bit is 0, its pinOe is 0, its input reads 0 and its periphIn bit is 0.
- R10: busRdata is loaded at the rising edge where busRd is 1. It holds its value while busRd is 0.
- R11: periphIn carries the synchronized pin level for every pin whose digital-enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 9 | Word address: bit 8 picks data window (0) or control register (1) |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| pinIn | input | 8 | Asynchronous pin levels |
| pinOut | output | 8 | Pin output values |
| pinOe | output | 8 | Pin output enables |
| periphOut | input | 8 | Peripheral output values |
| periphOe | input | 8 | Peripheral output enables |
| periphIn | output | 8 | Synchronized, enable-gated pin levels to the peripheral |

## Verification
The masked data path is driven with patterns that differ in write mask, read mask and per-pin direction. All-ones masks show that the full register is reached. Sparse masks such as 0x81, 0x0F and 0x00 show that unmasked bits survive writes and read as zero. Mixed direction words such as 0xF0, 0x0F and 0xAA, paired with pin levels unlike the stored data, show per bit whether the read comes from the register or from the pin. Directed cases then separate the peripheral hand-over from the register path, show the digital enable blocking both drive and receive, and find the exact edge at which a pin change first appears.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    SEL_DATA = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_ALT  = 3'd2,
    SEL_DEN  = 3'd3,
    SEL_NONE = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   dataWr;
    logic   dirWr;
    logic   altWr;
    logic   denWr;
    logic   rdEn;
    rdSel_e rdSel;
  } ctlStrb_t;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int ADDR_W = NUM_PINS + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic                busRd,
  output ctlStrb_t            strb,
  output logic [NUM_PINS-1:0] accMask
);
  logic inDataWin;
  assign inDataWin = ~busAddr[NUM_PINS];

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    strb.rdEn  = busRd;
    accMask    = '0;
    if (inDataWin) begin
      strb.dataWr = busWr;
      strb.rdSel  = SEL_DATA;
      accMask     = busAddr[NUM_PINS-1:0];
    end else begin
      unique case (busAddr[1:0])
        2'd0: begin strb.dirWr = busWr; strb.rdSel = SEL_DIR; end
        2'd1: begin strb.altWr = busWr; strb.rdSel = SEL_ALT; end
        2'd2: begin strb.denWr = busWr; strb.rdSel = SEL_DEN; end
        default: strb.rdSel = SEL_NONE;
      endcase
    end
  end

  AST_ONE_WR_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.dataWr, strb.dirWr, strb.altWr, strb.denWr})); // R6
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrb_t            strb,
  input  logic [NUM_PINS-1:0] accMask,
  input  logic [NUM_PINS-1:0] busWdata,
  input  logic [NUM_PINS-1:0] pinSync,
  input  logic [NUM_PINS-1:0] periphOut,
  input  logic [NUM_PINS-1:0] periphOe,
  output logic [NUM_PINS-1:0] busRdata,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] periphIn
);
  logic [NUM_PINS-1:0] dataQ, dirQ, altQ, denQ;
  logic [NUM_PINS-1:0] pinView, rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
      altQ  <= '0;
      denQ  <= '0;
    end else begin
      if (strb.dataWr) dataQ <= (dataQ & ~accMask) | (busWdata & accMask);
      if (strb.dirWr)  dirQ  <= busWdata;
      if (strb.altWr)  altQ  <= busWdata;
      if (strb.denWr)  denQ  <= busWdata;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pinView[i]  = dirQ[i] ? dataQ[i] : (pinSync[i] & denQ[i]);
    assign pinOut[i]   = altQ[i] ? periphOut[i] : dataQ[i];
    assign pinOe[i]    = denQ[i] & (altQ[i] ? periphOe[i] : dirQ[i]);
    assign periphIn[i] = pinSync[i] & denQ[i];
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_DATA: rdMux = pinView & accMask;
      SEL_DIR:  rdMux = dirQ;
      SEL_ALT:  rdMux = altQ;
      SEL_DEN:  rdMux = denQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busRdata <= '0;
    else if (strb.rdEn) busRdata <= rdMux;
  end

  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWr |=> ((dataQ & ~$past(accMask)) == ($past(dataQ) & ~$past(accMask)))); // R2

  AST_DATA_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dataWr |=> $stable(dataQ)); // R2

  AST_RD_UNMASKED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == SEL_DATA) |=> ((busRdata & ~$past(accMask)) == '0)); // R3

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(busRdata)); // R10
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int ADDR_W = NUM_PINS + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  input  logic [NUM_PINS-1:0] periphOut,
  input  logic [NUM_PINS-1:0] periphOe,
  output logic [NUM_PINS-1:0] periphIn
);
  ctlStrb_t            strb;
  logic [NUM_PINS-1:0] accMask;
  logic [NUM_PINS-1:0] pinSync;

  gpio_sync2 #(.WIDTH(NUM_PINS)) i_sync (
    .clk(clk), .rstN(rstN), .d(pinIn), .q(pinSync)
  );

  gpio_port_ctl #(.NUM_PINS(NUM_PINS)) i_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .strb(strb), .accMask(accMask)
  );

  gpio_port_dp #(.NUM_PINS(NUM_PINS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .accMask(accMask), .busWdata(busWdata),
    .pinSync(pinSync), .periphOut(periphOut), .periphOe(periphOe),
    .busRdata(busRdata), .pinOut(pinOut), .pinOe(pinOe), .periphIn(periphIn)
  );
endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut, pinOe, periphIn;
  logic [7:0] periphOut = '0;
  logic [7:0] periphOe = '0;

  int nCmp = 0;
  int nBad = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .periphOut(periphOut), .periphOe(periphOe), .periphIn(periphIn)
  );

  localparam logic [8:0] A_DIR = 9'h100;
  localparam logic [8:0] A_ALT = 9'h101;
  localparam logic [8:0] A_DEN = 9'h102;
  localparam logic [8:0] A_NONE = 9'h103;

  // dir, pin, pre, wrMask, wdata, rdMask, expRd, expOut
  localparam logic [63:0] VEC [8] = '{
    64'hFF_00_00_FF_A5_FF_A5_A5,
    64'hFF_FF_A5_0F_3C_FF_AC_AC,
    64'hFF_00_FF_81_00_F0_70_7E,
    64'h00_5A_00_FF_FF_FF_5A_FF,
    64'h00_C3_12_00_FF_0F_03_12,
    64'hF0_3C_00_FF_96_FF_9C_96,
    64'h0F_3C_96_55_00_3C_30_82,
    64'hAA_FF_00_01_FF_FF_55_01
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // both tasks begin just after a falling edge and end at a falling edge
  task automatic busWrite(input logic [8:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [8:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  function automatic logic [8:0] dataAddr(input logic [7:0] m);
    return {1'b0, m};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    pinIn = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    busRead(A_DIR, rd);  check("R1 dir", rd, 8'h00);
    busRead(A_ALT, rd);  check("R1 alt", rd, 8'h00);
    busRead(A_DEN, rd);  check("R1 den", rd, 8'h00);
    busRead(dataAddr(8'hFF), rd); check("R1 R9 data with den off", rd, 8'h00);
    check("R9 periphIn den off", periphIn, 8'h00);

    // R6 control registers
    busWrite(A_DEN, 8'hFF); busRead(A_DEN, rd); check("R6 den readback", rd, 8'hFF);
    busWrite(A_ALT, 8'h0F); busRead(A_ALT, rd); check("R6 alt readback", rd, 8'h0F);
    busWrite(A_ALT, 8'h00);
    busWrite(A_NONE, 8'hFF); busRead(A_NONE, rd); check("R6 unused reads 0", rd, 8'h00);
    busRead(A_DIR, rd); check("R6 unused write ignored dir", rd, 8'h00);
    busRead(A_ALT, rd); check("R6 unused write ignored alt", rd, 8'h00);

    // vector table: R2 R3 R4 R7
    for (int v = 0; v < 8; v++) begin
      busWrite(A_DIR, VEC[v][63:56]);
      busWrite(dataAddr(8'hFF), VEC[v][47:40]);
      busWrite(dataAddr(VEC[v][39:32]), VEC[v][31:24]);
      pinIn = VEC[v][55:48];
      repeat (3) @(negedge clk);
      busRead(dataAddr(VEC[v][23:16]), rd);
      check($sformatf("R2 R3 R4 vec%0d read", v), rd, VEC[v][15:8]);
      check($sformatf("R2 R7 vec%0d pinOut", v), pinOut, VEC[v][7:0]);
      check($sformatf("R7 vec%0d pinOe", v), pinOe, VEC[v][63:56]);
    end

    // R5 synchronizer latency, R11 peripheral input
    busWrite(A_DIR, 8'h00);
    pinIn = 8'h00;
    repeat (3) @(negedge clk);
    pinIn = 8'hA5;
    busRead(dataAddr(8'hFF), rd); check("R5 edge1 old", rd, 8'h00);
    busRead(dataAddr(8'hFF), rd); check("R5 edge2 old", rd, 8'h00);
    busRead(dataAddr(8'hFF), rd); check("R5 edge3 new", rd, 8'hA5);
    check("R11 periphIn", periphIn, 8'hA5);

    // R8 peripheral hand-over
    busWrite(dataAddr(8'hFF), 8'h00);
    periphOut = 8'hAA; periphOe = 8'hFF;
    busWrite(A_ALT, 8'hF0);
    check("R8 pinOut mix", pinOut, 8'hA0);
    check("R8 pinOe mix", pinOe, 8'hF0);
    periphOe = 8'h30;
    @(negedge clk);
    check("R8 pinOe follows periphOe", pinOe, 8'h30);

    // R9 digital enable off on upper nibble
    busWrite(A_DEN, 8'h0F);
    pinIn = 8'hFF;
    repeat (3) @(negedge clk);
    busRead(dataAddr(8'hFF), rd); check("R9 input gated", rd, 8'h0F);
    check("R9 R11 periphIn gated", periphIn, 8'h0F);
    busWrite(A_DIR, 8'hFF);
    check("R9 pinOe gated", pinOe, 8'h0F);

    // R10 read data holds without a read strobe
    busRead(A_DIR, rd); check("R10 read dir", rd, 8'hFF);
    busWrite(A_DIR, 8'h00);
    repeat (2) @(negedge clk);
    check("R10 hold", busRdata, 8'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule